// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Front End

This block is the host-facing register file of a small Ethernet controller. The host sees only two 16-bit ports. A write to the address port picks one of four internal registers. Later accesses to the data port read or write whichever register was picked last. Register 0 is the command-and-status register. It holds the command bits, the run indications, the interrupt enable and seven event flags. Registers 1 and 2 hold a 24-bit initialization-block address. Register 3 holds the bus-control settings.

The datapath is not part of this block. It appears only as one-cycle event pulses (`ev_flags`) and as acknowledge inputs for the init and transmit-demand commands. The block drives a level interrupt, one-cycle command strobes, a running indication and the configuration values. A two-state machine tracks the run state. `ST_STOPPED` is the reset state. A register-0 write with the start bit set and the stop bit clear takes the transition `STOP_TO_RUN` into `ST_RUNNING`. A register-0 write with the stop bit set takes `RUN_TO_STOP` back to `ST_STOPPED`. A stop write while stopped and a start write while running both leave the state unchanged.

Top module: `netctl_regs`

## Requirements
- R1: A write to the address port (`host_port`=0) stores `host_wdata[1:0]` as the register selection. The selection persists across any number of data-port accesses until the address port is written again.
- R2: While running, data-port writes to registers 1, 2 and 3 change nothing, and data-port reads of them return 0. While stopped, they are readable and writable.
- R3: In register 0, a written 1 in bit 0 (init) or bit 3 (transmit demand) sets that bit, and a written 0 there has no effect.
- R4: Register 0 reads as follows. Bit 1 is start, bit 2 is stop, and bits 4 and 5 are transmitter-on and receiver-on (all three equal the running state except bit 2, which is its inverse). Bit 6 is the read/write interrupt enable. Bit 7 is the OR of flags 8, 9, 10, 11, 12 and 14. Bit 15 is the OR of bits 11 to 14.
- R5: Flags in bits 14:8 are, in order: init done, transmit, receive, memory error, missed frame, signal quality, babble. `ev_flags[i]` sets bit 8+i. Writing 1 to bit 8+i clears it. An event in the same cycle as a clear of the same flag leaves the flag set.
- R6: After reset the block is in `ST_STOPPED`, register 0 reads 0x0004, the selection is 0, registers 1 to 3 read 0, and all outputs are 0.
- R7: A register-0 write with bit 1 set and bit 2 clear while stopped enters `ST_RUNNING`, so stop reads 0 and start, transmitter-on and receiver-on read 1. The same write while running changes nothing.
- R8: A register-0 write with bit 2 set enters `ST_STOPPED`. It clears init, transmit demand and all flags, overriding any start bit or event in the same cycle. The interrupt enable takes the written bit 6.
- R9: When init (or transmit demand) goes from 0 to 1, `init_strobe` (or `tdmd_strobe`) is high for exactly the one cycle in which the bit first reads 1. A set bit clears in the cycle after `init_ack` (or `tdmd_ack`).
- R10: `irq` is high exactly when register-0 bit 7 and bit 6 are both 1.
- R11: Register 1 stores bits 15:1 and reads bit 0 as 0. Register 2 stores all 16 bits, and register 3 stores all 16 bits. `init_addr` = {reg2[7:0], reg1[15:1], 0} and `bus_cfg` = reg3[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_port | input | 1 | 0 = address port, 1 = data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Data-port read value of the selected register |
| ev_flags | input | 7 | One-cycle event pulses, bit i sets flag 8+i |
| init_ack | input | 1 | Datapath accepted init command |
| tdmd_ack | input | 1 | Datapath accepted transmit demand |
| irq | output | 1 | Level interrupt |
| init_strobe | output | 1 | One-cycle init command strobe |
| tdmd_strobe | output | 1 | One-cycle transmit-demand strobe |
| running | output | 1 | Controller in `ST_RUNNING` |
| init_addr | output | 24 | Initialization-block address |
| bus_cfg | output | 3 | Byte swap, address-latch control, bus-hold control |

## Verification
The bench targets an event arriving in the same cycle as a host clear of that flag. A design that lets the clear win would lose an interrupt. It also writes registers 1 to 3 while running and reads them back; a broken lock would corrupt the address or leak its value. Stop and start are written together to catch a design that prioritises start and keeps running. The bench also checks that the selection survives data accesses, that signal quality does not feed the interrupt, and that strobes last one cycle and fire only on a 0-to-1 change. A wrong design would raise a spurious `irq` or issue repeated commands.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
    localparam int REG_W     = 16;
    localparam int SEL_W     = 2;
    localparam int NUM_FLAGS = 7;
    localparam int FLAG_LSB  = 8;
    localparam int ADDR_W    = 24;
    localparam int BUS_W     = 3;

    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_IEN   = 6;

    // flags that raise interrupt-pending (signal quality excluded)
    localparam logic [NUM_FLAGS-1:0] IRQ_MASK = 7'b101_1111;
    // flags summarised in the error bit
    localparam logic [NUM_FLAGS-1:0] ERR_MASK = 7'b111_1000;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/netctl_cmd_fsm.sv
module netctl_cmd_fsm
    import netctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0,
    input  logic [REG_W-1:0] wdata,
    input  logic             init_ack,
    input  logic             tdmd_ack,
    output logic             running,
    output logic             stop_clr,
    output logic             cmd_init,
    output logic             cmd_tdmd,
    output logic             init_strobe,
    output logic             tdmd_strobe
);
    run_state_e state_q, state_d;
    logic init_set, tdmd_set;

    assign stop_clr = wr0 && wdata[B_STOP];
    assign init_set = wr0 && !stop_clr && wdata[B_INIT] && !cmd_init;
    assign tdmd_set = wr0 && !stop_clr && wdata[B_TDMD] && !cmd_tdmd;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (wr0 && wdata[B_START] && !wdata[B_STOP]) state_d = ST_RUNNING;
            ST_RUNNING: if (stop_clr) state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_init    <= 1'b0;
            cmd_tdmd    <= 1'b0;
            init_strobe <= 1'b0;
            tdmd_strobe <= 1'b0;
        end else begin
            init_strobe <= init_set;
            tdmd_strobe <= tdmd_set;
            if (stop_clr)      cmd_init <= 1'b0;
            else if (cmd_init) cmd_init <= !init_ack;
            else               cmd_init <= init_set;
            if (stop_clr)      cmd_tdmd <= 1'b0;
            else if (cmd_tdmd) cmd_tdmd <= !tdmd_ack;
            else               cmd_tdmd <= tdmd_set;
        end
    end

    assign running = (state_q == ST_RUNNING);
endmodule

// File: rtl/netctl_flags.sv
module netctl_flags
    import netctl_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_clr,
    input  logic         wr0,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (stop_clr) flags[i] <= 1'b0;
            else               flags[i] <= ev[i] | (flags[i] & !(wr0 & clr_bits[i]));
        end
    end
endmodule

// File: rtl/netctl_cfg.sv
module netctl_cfg
    import netctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             wr_cfg,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] reg1,
    output logic [REG_W-1:0] reg2,
    output logic [REG_W-1:0] reg3
);
    logic [REG_W-1:1] addr_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            reg2      <= '0;
            reg3      <= '0;
        end else if (wr_cfg) begin
            unique case (sel)
                2'd1:    addr_lo_q <= wdata[REG_W-1:1];
                2'd2:    reg2      <= wdata;
                2'd3:    reg3      <= wdata;
                default: ;
            endcase
        end
    end

    assign reg1 = {addr_lo_q, 1'b0};
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
    import netctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic                 host_port,
    input  logic [REG_W-1:0]     host_wdata,
    output logic [REG_W-1:0]     host_rdata,
    input  logic [NUM_FLAGS-1:0] ev_flags,
    input  logic                 init_ack,
    input  logic                 tdmd_ack,
    output logic                 irq,
    output logic                 init_strobe,
    output logic                 tdmd_strobe,
    output logic                 running,
    output logic [ADDR_W-1:0]    init_addr,
    output logic [BUS_W-1:0]     bus_cfg
);
    logic [SEL_W-1:0]     sel_q;
    logic                 inea_q;
    logic [NUM_FLAGS-1:0] flags_q;
    logic                 wr0, wr_cfg, stop_clr, cmd_init, cmd_tdmd;
    logic                 pending, err_sum;
    logic [REG_W-1:0]     reg0, reg1, reg2, reg3;

    assign wr0    = host_we && host_port && (sel_q == '0);
    assign wr_cfg = host_we && host_port && (sel_q != '0) && !running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            inea_q <= 1'b0;
        end else begin
            if (host_we && !host_port) sel_q  <= host_wdata[SEL_W-1:0];
            if (wr0)                   inea_q <= host_wdata[B_IEN];
        end
    end

    netctl_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr0         (wr0),
        .wdata       (host_wdata),
        .init_ack    (init_ack),
        .tdmd_ack    (tdmd_ack),
        .running     (running),
        .stop_clr    (stop_clr),
        .cmd_init    (cmd_init),
        .cmd_tdmd    (cmd_tdmd),
        .init_strobe (init_strobe),
        .tdmd_strobe (tdmd_strobe)
    );

    netctl_flags #(.N(NUM_FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_clr (stop_clr),
        .wr0      (wr0),
        .clr_bits (host_wdata[FLAG_LSB +: NUM_FLAGS]),
        .ev       (ev_flags),
        .flags    (flags_q)
    );

    netctl_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_q),
        .wr_cfg (wr_cfg),
        .wdata  (host_wdata),
        .reg1   (reg1),
        .reg2   (reg2),
        .reg3   (reg3)
    );

    assign pending = |(flags_q & IRQ_MASK);
    assign err_sum = |(flags_q & ERR_MASK);
    assign reg0 = {err_sum, flags_q, pending, inea_q, running, running,
                   cmd_tdmd, !running, running, cmd_init};

    always_comb begin
        unique case (sel_q)
            2'd0:    host_rdata = reg0;
            2'd1:    host_rdata = running ? '0 : reg1;
            2'd2:    host_rdata = running ? '0 : reg2;
            default: host_rdata = running ? '0 : reg3;
        endcase
    end

    assign irq       = pending && inea_q;
    assign init_addr = {reg2[7:0], reg1};
    assign bus_cfg   = reg3[BUS_W-1:0];
endmodule

// File: rtl/netctl_regs_chk.sv
module netctl_regs_chk
    import netctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_we,
    input logic                 host_port,
    input logic [REG_W-1:0]     host_wdata,
    input logic [NUM_FLAGS-1:0] ev_flags,
    input logic                 irq,
    input logic                 init_strobe,
    input logic                 tdmd_strobe,
    input logic                 running,
    input logic [ADDR_W-1:0]    init_addr,
    input logic [BUS_W-1:0]     bus_cfg,
    input logic [SEL_W-1:0]     sel_q,
    input logic                 inea_q,
    input logic [NUM_FLAGS-1:0] flags_q
);
    logic w0;
    assign w0 = host_we && host_port && (sel_q == '0);

    a_r1_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && !host_port) |=> $stable(sel_q));

    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (running && host_we && host_port && sel_q != '0) |=> ($stable(init_addr) && $stable(bus_cfg)));

    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_flags != '0 && !(w0 && host_wdata[B_STOP])) |=> ((flags_q & $past(ev_flags)) == $past(ev_flags)));

    a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && host_wdata[B_START] && !host_wdata[B_STOP]) |=> running);

    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w0 && host_wdata[B_STOP]) |=> (!running && flags_q == '0));

    a_r9_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_strobe |=> !init_strobe);

    a_r9_tdmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tdmd_strobe |=> !tdmd_strobe);

    a_r10_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> inea_q);
endmodule

bind netctl_regs netctl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_port   (host_port),
    .host_wdata  (host_wdata),
    .ev_flags    (ev_flags),
    .irq         (irq),
    .init_strobe (init_strobe),
    .tdmd_strobe (tdmd_strobe),
    .running     (running),
    .init_addr   (init_addr),
    .bus_cfg     (bus_cfg),
    .sel_q       (sel_q),
    .inea_q      (inea_q),
    .flags_q     (flags_q)
);

// File: tb/tb_netctl_regs.sv
module tb_netctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_port = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  ev_flags = '0;
    logic        init_ack = 1'b0;
    logic        tdmd_ack = 1'b0;
    logic        irq, init_strobe, tdmd_strobe, running;
    logic [23:0] init_addr;
    logic [2:0]  bus_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [1:0]  m_sel;
    logic        m_stopped, m_init, m_tdmd, m_inea, m_istb, m_tstb;
    logic [6:0]  m_flags;
    logic [15:0] m_r1, m_r2, m_r3;

    always #5 clk = ~clk;

    netctl_regs dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_reg0();
        logic run, pend, err;
        run  = !m_stopped;
        pend = |(m_flags & 7'b101_1111);
        err  = |m_flags[6:3];
        return {err, m_flags, pend, m_inea, run, run, m_tdmd, m_stopped, run, m_init};
    endfunction

    function automatic logic [15:0] exp_rdata();
        if (m_sel == 2'd0) return exp_reg0();
        if (!m_stopped)    return 16'h0;
        case (m_sel)
            2'd1:    return m_r1;
            2'd2:    return m_r2;
            default: return m_r3;
        endcase
    endfunction

    task automatic model_reset();
        m_sel = 0; m_stopped = 1; m_init = 0; m_tdmd = 0; m_inea = 0;
        m_istb = 0; m_tstb = 0; m_flags = 0; m_r1 = 0; m_r2 = 0; m_r3 = 0;
    endtask

    task automatic model_step(input logic we, input logic port, input logic [15:0] wd,
                              input logic [6:0] ev, input logic ia, input logic ta);
        logic wr0, wrx, ni, nt;
        wr0 = we && port && m_sel == 0;
        wrx = we && port && m_sel != 0 && m_stopped;
        ni = 0; nt = 0;
        if (wrx) begin
            case (m_sel)
                2'd1:    m_r1 = wd & 16'hFFFE;
                2'd2:    m_r2 = wd;
                default: m_r3 = wd;
            endcase
        end
        if (we && !port) m_sel = wd[1:0];
        if (wr0 && wd[2]) begin
            m_stopped = 1; m_init = 0; m_tdmd = 0; m_flags = 0; m_inea = wd[6];
        end else begin
            m_flags = (m_flags & ~(wr0 ? wd[14:8] : 7'h0)) | ev;
            if (wr0) m_inea = wd[6];
            if (m_init) begin if (ia) m_init = 0; end
            else if (wr0 && wd[0]) begin m_init = 1; ni = 1; end
            if (m_tdmd) begin if (ta) m_tdmd = 0; end
            else if (wr0 && wd[3]) begin m_tdmd = 1; nt = 1; end
            if (wr0 && wd[1] && m_stopped) m_stopped = 0;
        end
        m_istb = ni; m_tstb = nt;
    endtask

    task automatic compare_all();
        check(m_sel == 0 ? "R4" : "R2", host_rdata, exp_rdata());
        check("R10", irq, (|(m_flags & 7'b101_1111)) && m_inea);
        check("R9", {init_strobe, tdmd_strobe}, {m_istb, m_tstb});
        check("R7", running, !m_stopped);
        check("R11", {init_addr, bus_cfg}, {m_r2[7:0], m_r1, m_r3[2:0]});
    endtask

    task automatic step(input logic we, input logic port, input logic [15:0] wd,
                        input logic [6:0] ev, input logic ia, input logic ta);
        @(negedge clk);
        host_we = we; host_port = port; host_wdata = wd;
        ev_flags = ev; init_ack = ia; tdmd_ack = ta;
        @(posedge clk);
        model_step(we, port, wd, ev, ia, ta);
        #2;
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 16'h0, 7'h0, 0, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R6: reset state
        check("R6", host_rdata, 16'h0004);
        check("R6", {irq, init_strobe, tdmd_strobe, running}, 4'h0);
        check("R6", {init_addr, bus_cfg}, 27'h0);

        // R11 / R1: configure while stopped, selection persists
        step(1, 0, 16'h0001, 0, 0, 0);
        step(1, 1, 16'hABCD, 0, 0, 0);
        check("R11", host_rdata, 16'hABCC);
        step(0, 1, 16'h0, 0, 0, 0);
        check("R1", host_rdata, 16'hABCC);
        step(1, 0, 16'h0002, 0, 0, 0);
        step(1, 1, 16'h5A12, 0, 0, 0);
        step(1, 0, 16'h0003, 0, 0, 0);
        step(1, 1, 16'hFFF5, 0, 0, 0);
        check("R11", bus_cfg, 3'd5);

        // R7: start, then R2 lock while running
        step(1, 0, 16'h0000, 0, 0, 0);
        step(1, 1, 16'h0042, 0, 0, 0);
        check("R7", host_rdata[5:0], 6'b110010);
        step(1, 0, 16'h0002, 0, 0, 0);
        check("R2", host_rdata, 16'h0000);
        step(1, 1, 16'h1234, 0, 0, 0);
        check("R2", init_addr, 24'h12ABCC);

        // R5: event and clear in same cycle -> set; R10 irq
        step(1, 0, 16'h0000, 0, 0, 0);
        step(0, 0, 16'h0, 7'b000_0010, 0, 0);
        check("R10", irq, 1'b1);
        step(1, 1, 16'h0240, 7'b000_0010, 0, 0);
        check("R5", host_rdata[9], 1'b1);
        step(1, 1, 16'h0240, 0, 0, 0);
        check("R5", host_rdata[9], 1'b0);
        // signal quality alone: error bit but no pending
        step(0, 0, 16'h0, 7'b010_0000, 0, 0);
        check("R4", {host_rdata[15], host_rdata[7], irq}, 3'b100);

        // R3 / R9: init and tdmd strobes, acks
        step(1, 1, 16'h0049, 0, 0, 0);
        check("R9", {init_strobe, tdmd_strobe}, 2'b11);
        step(1, 1, 16'h0049, 0, 0, 0);
        check("R9", {init_strobe, tdmd_strobe}, 2'b00);
        step(0, 0, 16'h0, 0, 1, 1);
        check("R3", host_rdata[3:0], 4'b0010);

        // R8: stop and start together -> stopped
        step(1, 1, 16'h0006, 7'h7F, 0, 0);
        check("R8", host_rdata, 16'h0004);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [15:0] wd;
            r  = $urandom();
            wd = $urandom();
            if (r[3:0] < 3)       step(1, 0, wd, r[10] ? 7'(1 << r[13:11]) : 7'h0, r[14], r[15]);
            else if (r[3:0] < 9) begin
                if (r[17:16] != 0) wd[2] = 1'b0;
                step(1, 1, wd, r[10] ? 7'(1 << r[13:11]) : 7'h0, r[14], r[15]);
            end else              step(0, r[4], wd, r[10] ? 7'(1 << r[13:11]) : 7'h0, r[14], r[15]);
        end
        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        $urandom(32'd1234);
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule